// File: doc/BRIEF.md
# Dual-Clock FIFO Almost-Empty / Almost-Full Flag Generator

This block produces the two programmable threshold flags of a dual-clock FIFO whose storage lives elsewhere. The write side supplies its binary write pointer, a one-cycle advance strobe and the write clock. The read side supplies its binary read pointer, its advance strobe and the read clock. Pointers are `log2(DEPTH)+1` bits wide, so a full and an empty memory have distinct differences. The read pointer counts every word taken out of memory. A word that has moved into a first-word-fall-through output register already counts as read, so it is not part of the fill level.

The almost-empty flag (`rd_almost_empty_n`, active low) is a register in the read clock domain. The almost-full flag (`wr_almost_full_n`, active low) is a register in the write clock domain. Each flag goes active on the same edge as the local pointer move that causes it. It goes inactive only after the far pointer has crossed the clock boundary as Gray code: a capture flop, then the flag flop itself. Two offsets set the thresholds. The empty offset X and the full offset Y take preset values on reset. The write side can reload either one through a small parallel port. The write side should do this only while both pointers are idle.

Top module: `fifo_almost_flags`

## Requirements
- R1: While reset is held, `rd_almost_empty_n` is 0 and `wr_almost_full_n` is 1. After reset, X and Y equal the parameters `AE_PRESET` and `AF_PRESET`, even if they were reloaded before the reset.
- R2: With fill level N = (written − removed) mod 2·DEPTH, and once both clocks have idled for a few cycles, `rd_almost_empty_n` is 0 when N ≤ X and 1 when N ≥ X+1.
- R3: In the same settled condition, `wr_almost_full_n` is 0 when N ≥ DEPTH−Y and 1 when N ≤ DEPTH−Y−1. This includes Y = 0, where only a completely full memory makes the flag 0.
- R4: A read edge (`rd_inc` = 1) that lowers N to X or below drives `rd_almost_empty_n` to 0 on that same read-clock edge.
- R5: After the write edge that raises N to X+1, `rd_almost_empty_n` stays 0 through the first read-clock edge at least one skew interval later. It becomes 1 on the next read-clock edge.
- R6: A write edge (`wr_inc` = 1) that raises N to DEPTH−Y drives `wr_almost_full_n` to 0 on that same write-clock edge.
- R7: After the read edge that lowers N to DEPTH−Y−1, `wr_almost_full_n` stays 0 through the first write-clock edge at least one skew interval later. It becomes 1 on the next write-clock edge.
- R8: On a write-clock edge with `off_load` = 1, the low `log2(DEPTH)` bits of `off_data` are loaded into X when `off_sel` = 0, or into Y when `off_sel` = 1. Y applies from the next write edge. X reaches the read domain two read edges later.
- R9: Both flags follow R2 and R3 while the pointers wrap around their 2·DEPTH range any number of times.
- R10: When reads and writes run at the same time and leave N unchanged, both flags settle to the values R2 and R3 give for that N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_ptr | input | log2(DEPTH)+1 | Binary write pointer, driven from a register |
| wr_inc | input | 1 | Write pointer advances on this write edge |
| off_load | input | 1 | Load an offset on this write edge |
| off_sel | input | 1 | Offset select: 0 = almost-empty X, 1 = almost-full Y |
| off_data | input | log2(DEPTH) | Offset value to load |
| wr_almost_full_n | output | 1 | Almost-full flag, 0 when N ≥ DEPTH−Y |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_ptr | input | log2(DEPTH)+1 | Binary read pointer, driven from a register |
| rd_inc | input | 1 | Read pointer advances on this read edge |
| rd_almost_empty_n | output | 1 | Almost-empty flag, 0 when N ≤ X |

## Verification
The bench builds the block with DEPTH = 16, AE_PRESET = 2 and AF_PRESET = 3. At that depth a completely full memory takes a handful of writes, and sixty writes and reads wrap the five-bit pointers twice. Reloading the offsets to 0 and 15 reaches both ends of the threshold range. The two clocks run at the same 50 MHz rate with a 7 ns phase offset, so the edge at which a crossing pointer is first captured is known exactly. That makes the one-edge hold and the second-edge release of each flag observable cycle by cycle.

// File: rtl/afg_pkg.sv
package afg_pkg;

    // Which offset register a parallel load targets.
    typedef enum logic {
        OFS_EMPTY = 1'b0,
        OFS_FULL  = 1'b1
    } ofs_sel_e;

    // Which clock domain a level flag lives in.
    typedef enum logic {
        SIDE_READ  = 1'b0,
        SIDE_WRITE = 1'b1
    } flag_side_e;

endpackage

// File: rtl/ptr_gray_sync.sv
module ptr_gray_sync #(
    parameter int unsigned PW = 10
) (
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    input  logic [PW-1:0] src_ptr,
    output logic [PW-1:0] dst_ptr_bin
);

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = int'(PW) - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    typedef struct packed {
        logic [PW-1:0] gray;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.gray = to_gray(src_ptr);
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // The capture flop is the first stage; the consuming flag flop is the second.
    assign dst_ptr_bin = from_gray(s_q.gray);

endmodule

// File: rtl/fifo_offset_regs.sv
module fifo_offset_regs
    import afg_pkg::*;
#(
    parameter int unsigned AW       = 9,
    parameter int unsigned X_PRESET = 8,
    parameter int unsigned Y_PRESET = 8
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          load,
    input  logic          sel,
    input  logic [AW-1:0] data,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    output logic [AW-1:0] y_wr,
    output logic [AW-1:0] x_rd
);

    localparam logic [AW-1:0] X_INIT = AW'(X_PRESET);
    localparam logic [AW-1:0] Y_INIT = AW'(Y_PRESET);

    typedef struct packed {
        logic [AW-1:0] x;
        logic [AW-1:0] y;
    } wr_st_t;

    typedef struct packed {
        logic [AW-1:0] x_s1;
        logic [AW-1:0] x_s2;
    } rd_st_t;

    wr_st_t w_d, w_q;
    rd_st_t r_d, r_q;

    always_comb begin
        w_d = w_q;
        if (load) begin
            if (sel == OFS_FULL) begin
                w_d.y = data;
            end else begin
                w_d.x = data;
            end
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            w_q <= '{x: X_INIT, y: Y_INIT};
        end else begin
            w_q <= w_d;
        end
    end

    // Quasi-static copy of X into the read domain.
    always_comb begin
        r_d      = r_q;
        r_d.x_s1 = w_q.x;
        r_d.x_s2 = r_q.x_s1;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            r_q <= '{x_s1: X_INIT, x_s2: X_INIT};
        end else begin
            r_q <= r_d;
        end
    end

    assign y_wr = w_q.y;
    assign x_rd = r_q.x_s2;

endmodule

// File: rtl/fifo_level_flag.sv
module fifo_level_flag
    import afg_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter flag_side_e  SIDE  = SIDE_READ,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] own_ptr,
    input  logic          own_inc,
    input  logic [PW-1:0] far_ptr,
    input  logic [AW-1:0] offset,
    output logic          flag_n
);

    localparam int unsigned LW       = PW + 1;
    localparam logic        RST_FLAG = (SIDE == SIDE_WRITE) ? 1'b1 : 1'b0;

    typedef struct packed {
        logic flag_n;
    } flag_st_t;

    flag_st_t      st_d, st_q;
    logic [PW-1:0] own_next;
    logic [PW-1:0] level;
    logic          flag_next;

    // Own pointer after this edge: local moves act on the flag at once.
    assign own_next = own_ptr + PW'(own_inc);

    if (SIDE == SIDE_READ) begin : g_empty_side
        assign level     = far_ptr - own_next;
        assign flag_next = (level > PW'(offset));
    end else begin : g_full_side
        assign level     = own_next - far_ptr;
        assign flag_next = ((LW'(level) + LW'(offset)) < LW'(DEPTH));
    end

    always_comb begin
        st_d        = st_q;
        st_d.flag_n = flag_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag_n <= RST_FLAG;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_n = st_q.flag_n;

endmodule

// File: rtl/fifo_almost_flags.sv
module fifo_almost_flags
    import afg_pkg::*;
#(
    parameter int unsigned DEPTH     = 512,
    parameter int unsigned AE_PRESET = 8,
    parameter int unsigned AF_PRESET = 8,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned PW       = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic [PW-1:0] wr_ptr,
    input  logic          wr_inc,
    input  logic          off_load,
    input  logic          off_sel,
    input  logic [AW-1:0] off_data,
    output logic          wr_almost_full_n,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic [PW-1:0] rd_ptr,
    input  logic          rd_inc,
    output logic          rd_almost_empty_n
);

    logic [PW-1:0] wsync_bin;
    logic [PW-1:0] rsync_bin;
    logic [AW-1:0] x_rd;
    logic [AW-1:0] y_wr;

    ptr_gray_sync #(.PW(PW)) u_wptr_to_rd (
        .dst_clk     (rd_clk),
        .dst_rst_n   (rd_rst_n),
        .src_ptr     (wr_ptr),
        .dst_ptr_bin (wsync_bin)
    );

    ptr_gray_sync #(.PW(PW)) u_rptr_to_wr (
        .dst_clk     (wr_clk),
        .dst_rst_n   (wr_rst_n),
        .src_ptr     (rd_ptr),
        .dst_ptr_bin (rsync_bin)
    );

    fifo_offset_regs #(
        .AW       (AW),
        .X_PRESET (AE_PRESET),
        .Y_PRESET (AF_PRESET)
    ) u_offsets (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .load     (off_load),
        .sel      (off_sel),
        .data     (off_data),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .y_wr     (y_wr),
        .x_rd     (x_rd)
    );

    fifo_level_flag #(.DEPTH(DEPTH), .SIDE(SIDE_READ)) u_empty_flag (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .own_ptr (rd_ptr),
        .own_inc (rd_inc),
        .far_ptr (wsync_bin),
        .offset  (x_rd),
        .flag_n  (rd_almost_empty_n)
    );

    fifo_level_flag #(.DEPTH(DEPTH), .SIDE(SIDE_WRITE)) u_full_flag (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .own_ptr (wr_ptr),
        .own_inc (wr_inc),
        .far_ptr (rsync_bin),
        .offset  (y_wr),
        .flag_n  (wr_almost_full_n)
    );

endmodule

// File: rtl/fifo_almost_flags_chk.sv
module fifo_almost_flags_chk #(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1,
    localparam int unsigned LW   = PW + 1
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic [PW-1:0] wr_ptr,
    input logic          wr_inc,
    input logic [PW-1:0] rd_ptr,
    input logic          rd_inc,
    input logic [PW-1:0] wsync_bin,
    input logic [PW-1:0] rsync_bin,
    input logic [AW-1:0] x_rd,
    input logic [AW-1:0] y_wr,
    input logic          ae_n,
    input logic          af_n
);

    logic [LW-1:0] rd_level;
    logic [LW-1:0] wr_level;

    assign rd_level = {1'b0, wsync_bin - rd_ptr};
    assign wr_level = {1'b0, wr_ptr - rsync_bin};

    // R1
    always @(negedge rd_clk) begin
        if (!rd_rst_n) begin
            reset_empty_chk: assert (ae_n == 1'b0);
        end
    end

    // R1
    always @(negedge wr_clk) begin
        if (!wr_rst_n) begin
            reset_full_chk: assert (af_n == 1'b1);
        end
    end

    // R2
    empty_level_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (ae_n && $stable(x_rd)) |-> (rd_level > LW'(x_rd)));

    // R3
    full_level_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (af_n && $stable(y_wr)) |-> ((wr_level + LW'(y_wr)) < LW'(DEPTH)));

    // R4
    empty_assert_now_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_inc && (rd_level != '0) && (rd_level <= (LW'(x_rd) + 1'b1))) |=> !ae_n);

    // R6
    full_assert_now_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_inc && ((wr_level + LW'(y_wr) + 1'b1) >= LW'(DEPTH))) |=> !af_n);

endmodule

bind fifo_almost_flags fifo_almost_flags_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .wr_ptr    (wr_ptr),
    .wr_inc    (wr_inc),
    .rd_ptr    (rd_ptr),
    .rd_inc    (rd_inc),
    .wsync_bin (wsync_bin),
    .rsync_bin (rsync_bin),
    .x_rd      (x_rd),
    .y_wr      (y_wr),
    .ae_n      (rd_almost_empty_n),
    .af_n      (wr_almost_full_n)
);

// File: tb/fifo_almost_flags_tb.sv
`timescale 1ns/1ps
module fifo_almost_flags_tb;

    localparam int unsigned DEPTH = 16;
    localparam int unsigned XP    = 2;
    localparam int unsigned YP    = 3;
    localparam int unsigned AW    = $clog2(DEPTH);
    localparam int unsigned PW    = AW + 1;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          wr_inc = 1'b0;
    logic          rd_inc = 1'b0;
    logic          off_load = 1'b0;
    logic          off_sel = 1'b0;
    logic [AW-1:0] off_data = '0;
    logic          af_n;
    logic          ae_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int x_m    = XP;
    int y_m    = YP;

    typedef struct {
        bit    is_full;
        bit    exp;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     push_ev;

    fifo_almost_flags #(
        .DEPTH(DEPTH), .AE_PRESET(XP), .AF_PRESET(YP)
    ) u_dut (
        .wr_clk            (wr_clk),
        .wr_rst_n          (wr_rst_n),
        .wr_ptr            (wr_ptr),
        .wr_inc            (wr_inc),
        .off_load          (off_load),
        .off_sel           (off_sel),
        .off_data          (off_data),
        .wr_almost_full_n  (af_n),
        .rd_clk            (rd_clk),
        .rd_rst_n          (rd_rst_n),
        .rd_ptr            (rd_ptr),
        .rd_inc            (rd_inc),
        .rd_almost_empty_n (ae_n)
    );

    always #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    // Pointer registers of the surrounding FIFO.
    always @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) wr_ptr <= '0;
        else if (wr_inc) wr_ptr <= wr_ptr + 1'b1;
    end
    always @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) rd_ptr <= '0;
        else if (rd_inc) rd_ptr <= rd_ptr + 1'b1;
    end

    function automatic int fill();
        return int'(PW'(wr_ptr - rd_ptr));
    endfunction

    task automatic expect_flag(input bit is_full, input bit exp, input string tag);
        sb_item_t it;
        it.is_full = is_full;
        it.exp     = exp;
        it.tag     = tag;
        sb_q.push_back(it);
        -> push_ev;
    endtask

    // Monitor: pops expected items and compares against the outputs.
    initial begin
        sb_item_t it;
        bit       act;
        forever begin
            @(push_ev);
            while (sb_q.size() > 0) begin
                it  = sb_q.pop_front();
                act = it.is_full ? af_n : ae_n;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: %s actual %0b expected %0b (fill %0d X %0d Y %0d)",
                             it.tag, it.is_full ? "almost_full_n" : "almost_empty_n",
                             act, it.exp, fill(), x_m, y_m);
                end
            end
        end
    end

    task automatic do_write(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk) wr_inc = 1'b1;
            @(posedge wr_clk) #1 wr_inc = 1'b0;
        end
    endtask

    task automatic do_read(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk) rd_inc = 1'b1;
            @(posedge rd_clk) #1 rd_inc = 1'b0;
        end
    endtask

    task automatic load_offset(input bit sel, input int val);
        @(negedge wr_clk);
        off_load = 1'b1;
        off_sel  = sel;
        off_data = AW'(val);
        @(posedge wr_clk) #1 off_load = 1'b0;
        if (sel) y_m = val;
        else     x_m = val;
    endtask

    task automatic settle();
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        @(negedge rd_clk);
    endtask

    task automatic check_levels(input string tag);
        settle();
        expect_flag(1'b0, fill() > x_m, tag);
        expect_flag(1'b1, fill() < int'(DEPTH) - y_m, tag);
    endtask

    task automatic apply_reset();
        @(negedge wr_clk);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        x_m = XP;
        y_m = YP;
        @(negedge rd_clk);
        // R1: reset values of both flags
        expect_flag(1'b0, 1'b0, "R1 reset");
        expect_flag(1'b1, 1'b1, "R1 reset");
        repeat (2) @(posedge wr_clk);
        @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        apply_reset();

        // R2: fill at X keeps almost-empty active
        do_write(2);
        check_levels("R2 fill=X");

        // R5: release on the second read edge after the write to X+1
        do_write(1);
        @(posedge rd_clk);
        @(negedge rd_clk);
        expect_flag(1'b0, 1'b0, "R5 first edge hold");
        @(posedge rd_clk);
        @(negedge rd_clk);
        expect_flag(1'b0, 1'b1, "R5 second edge release");
        check_levels("R2 fill=X+1");

        // R4: a read down to X acts on the same edge
        do_read(1);
        @(negedge rd_clk);
        expect_flag(1'b0, 1'b0, "R4 same-edge assert");

        // R3: just below DEPTH-Y
        do_write(10);
        check_levels("R3 fill=DEPTH-Y-1");

        // R6: the write to DEPTH-Y acts on the same edge
        do_write(1);
        @(negedge wr_clk);
        expect_flag(1'b1, 1'b0, "R6 same-edge assert");

        // R7: release on the second write edge after the read
        do_read(1);
        @(posedge wr_clk);
        @(negedge wr_clk);
        expect_flag(1'b1, 1'b0, "R7 first edge hold");
        @(posedge wr_clk);
        @(negedge wr_clk);
        expect_flag(1'b1, 1'b1, "R7 second edge release");

        // R10: concurrent traffic at two fill levels
        fork
            do_write(5);
            do_read(5);
        join
        check_levels("R10 fill=12");
        do_write(1);
        fork
            do_write(6);
            do_read(6);
        join
        check_levels("R10 fill=13");

        // R8: reload Y to 0, then full boundary (R3)
        load_offset(1'b1, 0);
        check_levels("R8 Y=0");
        do_write(2);
        check_levels("R3 Y=0 fill=15");
        do_write(1);
        check_levels("R3 Y=0 full");

        // R8: reload X at the top of its range
        load_offset(1'b0, 15);
        check_levels("R8 X=15 fill=16");
        do_read(1);
        check_levels("R2 X=15 fill=15");
        load_offset(1'b0, 14);
        check_levels("R8 X=14 fill=15");

        // R1: reset restores presets
        apply_reset();
        do_write(3);
        check_levels("R1 preset X");
        do_write(10);
        check_levels("R1 preset Y");
        do_read(10);
        check_levels("R1 after drain");

        // R9: pointers wrap several times
        for (int k = 0; k < 6; k++) begin
            do_write(10);
            check_levels("R9 wrap high");
            do_read(10);
            check_levels("R9 wrap low");
        end

        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule